// File: doc/BRIEF.md
# Profile-Driven Wavetable Address Sequencer

This block drives the address side of a 1024-word by 32-bit single-port table RAM that holds a waveform or a frequency sweep. Four segment descriptors are held inside the block, one for each value of a 2-bit profile input. Each 40-bit descriptor packs a start address, a stop address, a per-address hold time in sync clock cycles, a segment mode and a return-home flag. The start and stop addresses are split across non-adjacent bit groups. The block walks the RAM addresses that the active descriptor describes, and a RAM data-valid strobe follows every read.

The serial port shares the RAM through this block, and its writes always win. While a write request is raised, the write address goes to the RAM and playback freezes: both the address and the hold-time counter keep their values. When the request drops, playback continues from where it stopped. When the profile input changes, the new segment restarts from its start address at the next clock. What happens at the stop address depends on the return-home flag: the sweep either parks at the stop address or goes back to the start address and parks there.

Top module: `wavetable_addr_seq`

## Requirements
- R1: The stop address is {word[9:8], word[23:16]} and the start address is {word[3:0], word[15:10]}. Word bit 9 is the stop MSB and word bit 3 is the start MSB.
- R2: Word bits 39:24 give the hold time H. During playback each address is presented for H unfrozen cycles, and H = 0 behaves as H = 1.
- R3: Mode field word[7:5] = 0 keeps the address at the start address.
- R4: Any nonzero mode value, including 6 and 7, steps the address up by one per hold time, wrapping at 10 bits, until it equals the stop address.
- R5: With word[4] = 0, a sweep stays at the stop address until the profile changes.
- R6: With word[4] = 1, a sweep spends one hold time at the stop address, then moves to the start address and stays there.
- R7: After reset, or when the profile input differs from its value at the previous clock, the next clock loads the start address of the newly selected segment and restarts the hold count.
- R8: While wr_req is 1: ram_we = 1, ram_re = 0 and ram_addr = wr_addr. Otherwise ram_re = 1, ram_we = 0 and ram_addr is the playback address.
- R9: A write freezes the playback address and the hold count. When the write ends, playback continues from the frozen address with the hold count it had reached.
- R10: rd_valid is 1 exactly in the cycles that follow a cycle with ram_re = 1 (default read latency of one).
- R11: Reset clears all descriptors to zero, sets the playback address to 0 and the active profile to 0, and clears rd_valid.
- R12: cfg_we with cfg_sel = k replaces descriptor k at the next clock. A rewritten descriptor is used for decoding from then on; a new start address takes effect only at the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor load strobe |
| cfg_sel | input | 2 | Descriptor index to load |
| cfg_word | input | 40 | Descriptor value |
| profile | input | 2 | Active segment selector |
| wr_req | input | 1 | Serial-port write request |
| wr_addr | input | 10 | Serial-port write address |
| ram_addr | output | 10 | RAM address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| rd_valid | output | 1 | RAM read data valid |

## Verification
The assertions assume that wr_req, wr_addr, profile and the descriptor load inputs change only away from the rising clock edge and stay stable across it. They also assume that a descriptor being rewritten never has its hold time made shorter than the count already reached. The bench drives every input on the falling edge. It draws hold times from a small range (0 to 3) and keeps start-to-stop distances short, so that sweeps reach both the stop and return-home paths often. It also draws all eight mode codes, with profile switches and write bursts at random rates.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
   localparam int WS_ADDR_W  = 10;
   localparam int WS_DWELL_W = 16;
   localparam int WS_WORD_W  = 40;

   localparam logic [2:0] WS_MODE_PARK = 3'd0;

   typedef struct packed {
      logic [WS_DWELL_W-1:0] hold;
      logic [WS_ADDR_W-1:0]  first;
      logic [WS_ADDR_W-1:0]  last;
      logic [2:0]            mode;
      logic                  go_home;
   } seg_t;

   // Field positions are fixed by the descriptor layout (R1).
   function automatic seg_t seg_decode(input logic [WS_WORD_W-1:0] w);
      seg_t s;
      s.hold    = w[39:24];
      s.last    = {w[9:8], w[23:16]};
      s.first   = {w[3:0], w[15:10]};
      s.mode    = w[7:5];
      s.go_home = w[4];
      return s;
   endfunction
endpackage

// File: rtl/wseq_seg_bank.sv
module wseq_seg_bank
   import wseq_pkg::*;
#(
   parameter int NUM_PROF = 4,
   parameter int WORD_W   = WS_WORD_W,
   localparam int SEL_W   = $clog2(NUM_PROF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [WORD_W-1:0] cfg_word,
   input  logic [SEL_W-1:0]  prof,
   output seg_t              seg_o
);
   if (WORD_W != WS_WORD_W) begin : g_bad_word
      $error("descriptor width must match the packed layout");
   end
   if ((1 << SEL_W) != NUM_PROF) begin : g_bad_prof
      $error("profile count must be a power of two");
   end

   logic [WORD_W-1:0] words [NUM_PROF];

   for (genvar i = 0; i < NUM_PROF; i++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (cfg_we && (cfg_sel == SEL_W'(i)))
            word_q <= cfg_word;
      end
      assign words[i] = word_q;
   end

   assign seg_o = seg_decode(words[prof]);
endmodule

// File: rtl/wseq_dwell_timer.sv
module wseq_dwell_timer #(
   parameter int DWELL_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               freeze,
   input  logic [DWELL_W-1:0] hold,
   output logic               tick
);
   if (DWELL_W < 1) begin : g_bad_w
      $error("hold width must be positive");
   end

   logic [DWELL_W-1:0] cnt_q;
   logic [DWELL_W-1:0] last_cnt;

   // A hold of zero is promoted to one (R2).
   assign last_cnt = (hold == '0) ? '0 : hold - 1'b1;
   assign tick     = !restart && !freeze && (cnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (!freeze)
         cnt_q <= (cnt_q >= last_cnt) ? '0 : cnt_q + 1'b1;
   end

   // R9: a write leaves the hold count untouched
   a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !restart) |=> $stable(cnt_q));

   // R7: restart clears the hold count
   a_r7_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));
endmodule

// File: rtl/wseq_addr_gen.sv
module wseq_addr_gen
   import wseq_pkg::*;
#(
   parameter int ADDR_W = WS_ADDR_W,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  prof,
   input  seg_t              seg,
   input  logic              freeze,
   input  logic              tick,
   output logic              restart,
   output logic [ADDR_W-1:0] play_addr
);
   if (ADDR_W != WS_ADDR_W) begin : g_bad_addr
      $error("address width is fixed by the descriptor layout");
   end

   logic [SEL_W-1:0]  prof_q;
   logic              boot_q;
   logic              parked_q;
   logic [ADDR_W-1:0] cur_q;
   logic              advance;

   assign restart   = boot_q || (prof != prof_q);
   assign advance   = tick && !freeze && (seg.mode != WS_MODE_PARK) && !parked_q;
   assign play_addr = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prof_q   <= '0;
         boot_q   <= 1'b1;
         parked_q <= 1'b0;
         cur_q    <= '0;
      end else begin
         prof_q <= prof;
         boot_q <= 1'b0;
         if (restart) begin
            cur_q    <= seg.first;
            parked_q <= 1'b0;
         end else if (advance) begin
            if (cur_q != seg.last)
               cur_q <= cur_q + 1'b1;
            else if (seg.go_home) begin
               cur_q    <= seg.first;
               parked_q <= 1'b1;
            end
         end
      end
   end

   // R7: a restart lands on the start address of the selected segment
   a_r7_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cur_q == $past(seg.first)));

   // R3: park mode never moves the address
   a_r3_park_still: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && seg.mode == WS_MODE_PARK) |=> $stable(cur_q));

   // R9: the playback address is held through a write
   a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !restart) |=> $stable(cur_q));

   // R5: without return-home, the stop address is sticky
   a_r5_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !seg.go_home && cur_q == seg.last) |=> $stable(cur_q));
endmodule

// File: rtl/wseq_port_arb.sv
module wseq_port_arb #(
   parameter int ADDR_W = 10,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] play_addr,
   output logic              freeze,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_re,
   output logic              ram_we,
   output logic              rd_valid
);
   if (RD_LAT < 1) begin : g_bad_lat
      $error("read latency must be at least one cycle");
   end

   // The serial port always wins the single RAM port (R8).
   assign freeze   = wr_req;
   assign ram_we   = wr_req;
   assign ram_re   = !wr_req;
   assign ram_addr = wr_req ? wr_addr : play_addr;

   if (RD_LAT == 1) begin : g_lat1
      logic vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q <= 1'b0;
         else        vld_q <= ram_re;
      end
      assign rd_valid = vld_q;

      // R10: a strobe follows each read and only a read
      a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
         ram_re |=> rd_valid);
      a_r10_no_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
         !ram_re |=> !rd_valid);
   end else begin : g_latn
      logic [RD_LAT-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[RD_LAT-2:0], ram_re};
      end
      assign rd_valid = pipe_q[RD_LAT-1];
   end

   // R8: the write address reaches the RAM and never alongside a read
   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (ram_we && !ram_re && ram_addr == wr_addr));
endmodule

// File: rtl/wavetable_addr_seq.sv
module wavetable_addr_seq
   import wseq_pkg::*;
#(
   parameter int NUM_PROF = 4,
   parameter int ADDR_W   = WS_ADDR_W,
   parameter int DWELL_W  = WS_DWELL_W,
   parameter int WORD_W   = WS_WORD_W,
   parameter int RD_LAT   = 1,
   localparam int SEL_W   = $clog2(NUM_PROF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [WORD_W-1:0] cfg_word,
   input  logic [SEL_W-1:0]  profile,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_re,
   output logic              ram_we,
   output logic              rd_valid
);
   if (DWELL_W != WS_DWELL_W) begin : g_bad_dwell
      $error("hold width is fixed by the descriptor layout");
   end

   seg_t              seg;
   logic              restart;
   logic              freeze;
   logic              tick;
   logic [ADDR_W-1:0] play_addr;

   wseq_seg_bank #(.NUM_PROF(NUM_PROF), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_word(cfg_word), .prof(profile), .seg_o(seg)
   );

   wseq_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .freeze(freeze),
      .hold(seg.hold), .tick(tick)
   );

   wseq_addr_gen #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .prof(profile), .seg(seg), .freeze(freeze),
      .tick(tick), .restart(restart), .play_addr(play_addr)
   );

   wseq_port_arb #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_arb (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .play_addr(play_addr), .freeze(freeze), .ram_addr(ram_addr),
      .ram_re(ram_re), .ram_we(ram_we), .rd_valid(rd_valid)
   );
endmodule

// File: tb/tb_wavetable_addr_seq.sv
module tb_wavetable_addr_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [39:0] cfg_word = '0;
   logic [1:0]  profile = '0;
   logic        wr_req = 1'b0;
   logic [9:0]  wr_addr = '0;
   logic [9:0]  ram_addr;
   logic        ram_re, ram_we, rd_valid;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   string cur_req = "R11";

   // reference state built from the requirements
   logic [39:0] m_words [4];
   logic [1:0]  m_prof;
   logic        m_boot;
   logic [9:0]  m_addr;
   int          m_cnt;
   logic        m_parked;
   logic        m_rv;

   always #4 clk = ~clk;

   wavetable_addr_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_word(cfg_word), .profile(profile), .wr_req(wr_req),
      .wr_addr(wr_addr), .ram_addr(ram_addr), .ram_re(ram_re),
      .ram_we(ram_we), .rd_valid(rd_valid)
   );

   function automatic logic [39:0] mk_word(input logic [9:0] first, input logic [9:0] last,
                                           input logic [15:0] hold, input logic [2:0] mode,
                                           input logic home);
      return {hold, last[7:0], first[5:0], last[9:8], mode, home, first[9:6]};
   endfunction
   function automatic logic [9:0] w_first(input logic [39:0] w);
      return {w[3:0], w[15:10]};
   endfunction
   function automatic logic [9:0] w_last(input logic [39:0] w);
      return {w[9:8], w[23:16]};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) m_words[i] = '0;
      m_prof = '0; m_boot = 1'b1; m_addr = '0; m_cnt = 0; m_parked = 1'b0; m_rv = 1'b0;
   endtask

   task automatic model_update();
      logic [39:0] w;
      int hold;
      w = m_words[profile];
      hold = (w[39:24] == 0) ? 1 : int'(w[39:24]);
      if (m_boot || profile != m_prof) begin
         m_addr = w_first(w); m_cnt = 0; m_parked = 1'b0;
      end else if (!wr_req) begin
         if (m_cnt >= hold - 1) begin
            m_cnt = 0;
            if (w[7:5] != 3'd0 && !m_parked) begin
               if (m_addr != w_last(w)) m_addr = m_addr + 10'd1;
               else if (w[4]) begin m_addr = w_first(w); m_parked = 1'b1; end
            end
         end else m_cnt++;
      end
      m_boot = 1'b0;
      m_prof = profile;
      m_rv   = !wr_req;
      if (cfg_we) m_words[cfg_sel] = cfg_word;
   endtask

   // called at a falling edge with inputs already applied
   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         #1;
         chk(ram_we === wr_req, "R8", ram_we, wr_req);
         chk(ram_re === !wr_req, "R8", ram_re, !wr_req);
         chk(ram_addr === (wr_req ? wr_addr : m_addr), wr_req ? "R8" : cur_req,
             ram_addr, wr_req ? wr_addr : m_addr);
         chk(rd_valid === m_rv, "R10", rd_valid, m_rv);
         model_update();
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic load(input logic [1:0] sel, input logic [39:0] w);
      cfg_we = 1'b1; cfg_sel = sel; cfg_word = w;
      step(1);
      cfg_we = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11: state right after reset
      chk(ram_addr === 10'd0, "R11", ram_addr, 0);
      chk(rd_valid === 1'b0, "R11", rd_valid, 0);
      chk(ram_re === 1'b1, "R11", ram_re, 1);

      cur_req = "R12";
      load(2'd1, mk_word(10'h205, 10'h209, 16'd3, 3'd1, 1'b0));
      load(2'd2, mk_word(10'd20, 10'd22, 16'd2, 3'd3, 1'b1));
      load(2'd3, mk_word(10'd40, 10'd50, 16'd1, 3'd0, 1'b0));
      load(2'd0, mk_word(10'd100, 10'd102, 16'd0, 3'd6, 1'b0));

      cur_req = "R7";
      profile = 2'd1; step(1);
      chk(ram_addr === 10'h205, "R1", ram_addr, 10'h205);
      cur_req = "R2";
      step(3);
      chk(ram_addr === 10'h206, "R2", ram_addr, 10'h206);
      cur_req = "R5";
      step(30);
      chk(ram_addr === 10'h209, "R5", ram_addr, 10'h209);

      cur_req = "R6";
      profile = 2'd2; step(20);
      chk(ram_addr === 10'd20, "R6", ram_addr, 20);

      cur_req = "R3";
      profile = 2'd3; step(10);
      chk(ram_addr === 10'd40, "R3", ram_addr, 40);

      cur_req = "R4";
      profile = 2'd0; step(1);
      chk(ram_addr === 10'd100, "R7", ram_addr, 100);
      step(1);
      chk(ram_addr === 10'd101, "R4", ram_addr, 101);

      cur_req = "R9";
      profile = 2'd1; step(5);
      wr_req = 1'b1; wr_addr = 10'h3FF; #1;
      chk(ram_addr === 10'h3FF && ram_we && !ram_re, "R8", ram_addr, 10'h3FF);
      step(3);
      wr_req = 1'b0; #1;
      chk(ram_addr === 10'h206, "R9", ram_addr, 10'h206);
      chk(rd_valid === 1'b0, "R10", rd_valid, 0);
      step(1);
      chk(ram_addr === 10'h206, "R9", ram_addr, 10'h206);
      chk(rd_valid === 1'b1, "R10", rd_valid, 1);
      step(1);
      chk(ram_addr === 10'h207, "R9", ram_addr, 10'h207);

      cur_req = "R4";
      for (int n = 0; n < 4000; n++) begin
         logic [9:0] f;
         f = 10'($urandom);
         cfg_we = ($urandom % 100) < 4;
         cfg_sel = 2'($urandom);
         cfg_word = mk_word(f, f + 10'($urandom % 7), 16'($urandom % 4),
                            3'($urandom), 1'($urandom));
         if (($urandom % 100) < 5) profile = 2'($urandom);
         wr_req = ($urandom % 100) < 20;
         wr_addr = 10'($urandom);
         step(1);
      end
      cfg_we = 1'b0; wr_req = 1'b0;
      step(2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule